// File: doc/BRIEF.md
# XY Dimension-Order Route Unit

This block sits behind one input port of a five-port router in a two-dimensional mesh. It watches the flit at the head of that port's input buffer. When a header flit arrives, it compares the destination column and row in the header with the router's own position, which is fixed by parameters. The X axis is resolved first and the Y axis second. The result is one of five outputs: Local, North, East, South or West.

The chosen output is then requested from the output allocator, which is outside this block. The request is held until the allocator grants that same output. From then on the path is owned for the whole packet, as wormhole switching requires. Body and tail flits pass to the same output without being decoded again, and each one waits while the downstream side of that output signals busy. The cycle after the tail flit is accepted, the request drops and the next header can be routed.

Top module: `xy_route_unit`

## Requirements
- R1: After reset the unit owns no path: the allocator request, the crossbar select, the ready and the forward strobe are all zero.
- R2: Output ports are one-hot in the bit order Local=bit0, North=bit1, East=bit2, South=bit3, West=bit4. A header whose destination equals the local coordinates selects Local.
- R3: The X axis is compared first. A destination column greater than the local column selects East, and a smaller one selects West, whatever the destination row.
- R4: When the columns match, a destination row greater than the local row selects South, and a smaller one selects North.
- R5: The cycle after a header (flit type 01) is seen while no path is owned, the request for the computed port is raised. It stays unchanged, with ready low, until a matching grant arrives.
- R6: A grant on a port other than the requested one has no effect: the request stays and ready stays low.
- R7: The cycle after a matching grant, the path is owned. A flit is accepted (ready high) only while the owned output's busy bit is low. While it is accepted, the crossbar select equals the owned port.
- R8: Body (10) and tail (11) flits follow the owned port, whatever the destination bits presented with them.
- R9: The cycle after a tail flit is accepted, the request and the select are zero. A following header is routed from its own destination.
- R10: Body or tail flits presented while no path is owned raise no request.
- R11: An idle flit type (00) on an owned path is not forwarded: the forward strobe and the select stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_kind_i | input | 2 | Type of the flit at the buffer head: 00 idle, 01 header, 10 body, 11 tail |
| hdr_dest_i | input | 2*COORD_W | Destination of a header flit: X in the low COORD_W bits, Y in the next COORD_W bits |
| alloc_req_o | output | 5 | One-hot request to the output allocator, held for the whole packet |
| alloc_gnt_i | input | 5 | Grant from the allocator, one bit per output |
| out_busy_i | input | 5 | Downstream busy, one bit per output |
| flit_ready_o | output | 1 | The input buffer may pop its head flit this cycle |
| flit_fwd_o | output | 1 | A non-idle flit is passed to the crossbar this cycle |
| xbar_sel_o | output | 5 | One-hot crossbar column select, nonzero only while forwarding |

## Verification
A wrong route register shows up at the allocator request one cycle after the header. It then persists on the select of every later flit of the packet, so each body and tail flit gives a second view of it. A state machine that releases early or late shows up as a request that is still present, or already gone, in the cycle after the tail is accepted. A lost busy qualification shows up at once as ready going high while the owned output is busy. The bench routes every destination of a 5x5 mesh from its centre, and mixes wrong-port grants, busy stalls and idle gaps into those packets.

// File: rtl/xyr_pkg.sv
package xyr_pkg;
    localparam int NUM_PORTS  = 5;
    localparam int PORT_LOCAL = 0;
    localparam int PORT_NORTH = 1;
    localparam int PORT_EAST  = 2;
    localparam int PORT_SOUTH = 3;
    localparam int PORT_WEST  = 4;

    typedef enum logic [1:0] {
        FK_IDLE = 2'b00,
        FK_HEAD = 2'b01,
        FK_BODY = 2'b10,
        FK_TAIL = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        PS_FREE = 2'b00,
        PS_ASK  = 2'b01,
        PS_OWN  = 2'b10
    } path_state_e;

    typedef struct packed {
        path_state_e          state;
        logic [NUM_PORTS-1:0] route;
    } path_regs_t;
endpackage

// File: rtl/xyr_route_calc.sv
module xyr_route_calc
    import xyr_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int HERE_X  = 2,
    parameter int HERE_Y  = 2
) (
    input  logic [COORD_W-1:0]   dst_x,
    input  logic [COORD_W-1:0]   dst_y,
    output logic [NUM_PORTS-1:0] dir_onehot
);
    localparam logic [COORD_W-1:0] HX = COORD_W'(HERE_X);
    localparam logic [COORD_W-1:0] HY = COORD_W'(HERE_Y);

    logic x_more, x_less, y_more, y_less;

    always_comb begin
        x_more = dst_x > HX;
        x_less = dst_x < HX;
        y_more = dst_y > HY;
        y_less = dst_y < HY;
        dir_onehot = '0;
        if (x_more) begin
            dir_onehot[PORT_EAST] = 1'b1;
        end else if (x_less) begin
            dir_onehot[PORT_WEST] = 1'b1;
        end else if (y_more) begin
            dir_onehot[PORT_SOUTH] = 1'b1;
        end else if (y_less) begin
            dir_onehot[PORT_NORTH] = 1'b1;
        end else begin
            dir_onehot[PORT_LOCAL] = 1'b1;
        end
    end
endmodule

// File: rtl/xyr_path_ctrl.sv
module xyr_path_ctrl
    import xyr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           kind,
    input  logic [NUM_PORTS-1:0] route_new,
    input  logic [NUM_PORTS-1:0] gnt,
    input  logic                 fwd,
    output logic [NUM_PORTS-1:0] req,
    output logic                 own,
    output logic [NUM_PORTS-1:0] route
);
    path_regs_t regs_d, regs_q;
    logic       granted;
    logic       tail_done;

    always_comb begin
        regs_d    = regs_q;
        granted   = |(gnt & regs_q.route);
        tail_done = fwd && (kind == FK_TAIL);
        case (regs_q.state)
            PS_FREE: begin
                if (kind == FK_HEAD) begin
                    regs_d.state = PS_ASK;
                    regs_d.route = route_new;
                end
            end
            PS_ASK: begin
                if (granted) begin
                    regs_d.state = PS_OWN;
                end
            end
            PS_OWN: begin
                if (tail_done) begin
                    regs_d.state = PS_FREE;
                    regs_d.route = '0;
                end
            end
            default: begin
                regs_d.state = PS_FREE;
                regs_d.route = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= PS_FREE;
            regs_q.route <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign own   = (regs_q.state == PS_OWN);
    assign route = regs_q.route;
    assign req   = (regs_q.state == PS_FREE) ? '0 : regs_q.route;
endmodule

// File: rtl/xyr_flow_gate.sv
module xyr_flow_gate
    import xyr_pkg::*;
(
    input  logic                 own,
    input  logic [NUM_PORTS-1:0] route,
    input  logic [NUM_PORTS-1:0] busy,
    input  logic [1:0]           kind,
    output logic                 ready,
    output logic                 fwd,
    output logic [NUM_PORTS-1:0] sel
);
    logic blocked;

    always_comb begin
        blocked = |(busy & route);
        ready   = own && !blocked;
        fwd     = ready && (kind != FK_IDLE);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
        assign sel[p] = fwd && route[p];
    end
endmodule

// File: rtl/xy_route_unit.sv
module xy_route_unit
    import xyr_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int HERE_X  = 2,
    parameter int HERE_Y  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             flit_kind_i,
    input  logic [2*COORD_W-1:0]   hdr_dest_i,
    output logic [NUM_PORTS-1:0]   alloc_req_o,
    input  logic [NUM_PORTS-1:0]   alloc_gnt_i,
    input  logic [NUM_PORTS-1:0]   out_busy_i,
    output logic                   flit_ready_o,
    output logic                   flit_fwd_o,
    output logic [NUM_PORTS-1:0]   xbar_sel_o
);
    localparam int Y_LSB = COORD_W;

    logic [NUM_PORTS-1:0] route_new;
    logic [NUM_PORTS-1:0] route_q;
    logic                 own_q;

    xyr_route_calc #(
        .COORD_W (COORD_W),
        .HERE_X  (HERE_X),
        .HERE_Y  (HERE_Y)
    ) u_calc (
        .dst_x      (hdr_dest_i[COORD_W-1:0]),
        .dst_y      (hdr_dest_i[Y_LSB +: COORD_W]),
        .dir_onehot (route_new)
    );

    xyr_path_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (flit_kind_i),
        .route_new (route_new),
        .gnt       (alloc_gnt_i),
        .fwd       (flit_fwd_o),
        .req       (alloc_req_o),
        .own       (own_q),
        .route     (route_q)
    );

    xyr_flow_gate u_gate (
        .own   (own_q),
        .route (route_q),
        .busy  (out_busy_i),
        .kind  (flit_kind_i),
        .ready (flit_ready_o),
        .fwd   (flit_fwd_o),
        .sel   (xbar_sel_o)
    );
endmodule

// File: rtl/xy_route_unit_chk.sv
module xy_route_unit_chk
    import xyr_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           flit_kind_i,
    input logic [2*COORD_W-1:0] hdr_dest_i,
    input logic [NUM_PORTS-1:0] alloc_req_o,
    input logic [NUM_PORTS-1:0] alloc_gnt_i,
    input logic [NUM_PORTS-1:0] out_busy_i,
    input logic                 flit_ready_o,
    input logic                 flit_fwd_o,
    input logic [NUM_PORTS-1:0] xbar_sel_o
);
    logic tail_acc;
    assign tail_acc = flit_fwd_o && (flit_kind_i == FK_TAIL);

    a_r2_req_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_req_o));

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((|alloc_req_o) && !tail_acc) |=> $stable(alloc_req_o));

    a_r7_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_busy_i & alloc_req_o)) |-> !flit_ready_o);

    a_r7_sel_is_req: assert property (@(posedge clk) disable iff (!rst_n)
        flit_fwd_o |-> ($onehot(xbar_sel_o) && (xbar_sel_o == alloc_req_o)));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        tail_acc |=> (alloc_req_o == '0));

    a_r10_no_stray_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_req_o == '0) && (flit_kind_i != FK_HEAD)) |=> (alloc_req_o == '0));

    a_r11_idle_not_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_kind_i == FK_IDLE) |-> (!flit_fwd_o && (xbar_sel_o == '0)));
endmodule

bind xy_route_unit xy_route_unit_chk #(.COORD_W(COORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flit_kind_i  (flit_kind_i),
    .hdr_dest_i   (hdr_dest_i),
    .alloc_req_o  (alloc_req_o),
    .alloc_gnt_i  (alloc_gnt_i),
    .out_busy_i   (out_busy_i),
    .flit_ready_o (flit_ready_o),
    .flit_fwd_o   (flit_fwd_o),
    .xbar_sel_o   (xbar_sel_o)
);

// File: tb/xy_route_unit_tb.sv
module xy_route_unit_tb;
    localparam int CW = 3;
    localparam int HX = 2;
    localparam int HY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    kind = 2'b00;
    logic [2*CW-1:0] dest = '0;
    logic [4:0]    req;
    logic [4:0]    gnt = '0;
    logic [4:0]    busy = '0;
    logic          ready;
    logic          fwd;
    logic [4:0]    sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xy_route_unit #(.COORD_W(CW), .HERE_X(HX), .HERE_Y(HY)) u_dut (
        .clk(clk), .rst_n(rst_n), .flit_kind_i(kind), .hdr_dest_i(dest),
        .alloc_req_o(req), .alloc_gnt_i(gnt), .out_busy_i(busy),
        .flit_ready_o(ready), .flit_fwd_o(fwd), .xbar_sel_o(sel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] expect_dir(input int dx, input int dy);
        if (dx > HX) return 5'b00100;
        if (dx < HX) return 5'b10000;
        if (dy > HY) return 5'b01000;
        if (dy < HY) return 5'b00010;
        return 5'b00001;
    endfunction

    task automatic send_pkt(input int dx, input int dy, input int nbody,
                            input int stall, input bit wrong_gnt, input bit gap);
        logic [4:0] e;
        e = expect_dir(dx, dy);
        @(negedge clk);
        kind = 2'b01;
        dest = {CW'(dy), CW'(dx)};
        #1 chk(req == 5'b0, "R9 no request before header", req, 0);
        @(negedge clk);
        #1;
        if (dx == HX && dy == HY)      chk(req == e, "R2 local", req, e);
        else if (dx != HX)             chk(req == e, "R3 x first", req, e);
        else                           chk(req == e, "R4 y axis", req, e);
        chk(ready == 1'b0, "R5 ready low while asking", ready, 0);
        if (wrong_gnt) begin
            gnt = ~e;
            @(negedge clk);
            #1 chk(req == e && ready == 1'b0, "R6 foreign grant ignored", req, e);
        end
        gnt = e;
        @(negedge clk);
        gnt = '0;
        for (int s = 0; s < stall; s++) begin
            busy = e;
            #1 chk(ready == 1'b0 && fwd == 1'b0, "R7 busy stalls", ready, 0);
            @(negedge clk);
        end
        busy = ~e;
        #1 chk(ready && fwd && sel == e, "R7 header forwarded", sel, e);
        for (int b = 0; b < nbody; b++) begin
            @(negedge clk);
            kind = 2'b10;
            dest = ~dest;
            #1 chk(fwd && sel == e, "R8 body follows", sel, e);
            if (gap && b == 0) begin
                @(negedge clk);
                kind = 2'b00;
                #1 chk(!fwd && sel == 5'b0 && ready, "R11 idle not forwarded", sel, 0);
            end
        end
        @(negedge clk);
        kind = 2'b11;
        dest = ~dest;
        #1 chk(fwd && sel == e, "R8 tail follows", sel, e);
        @(negedge clk);
        kind = 2'b00;
        busy = '0;
        #1 chk(req == 5'b0 && sel == 5'b0, "R9 released after tail", req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(req == 0 && sel == 0 && !ready && !fwd, "R1 reset state", req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        kind = 2'b10;
        @(negedge clk);
        kind = 2'b11;
        #1 chk(req == 5'b0, "R10 stray body ignored", req, 0);
        @(negedge clk);
        kind = 2'b00;
        #1 chk(req == 5'b0, "R10 stray tail ignored", req, 0);
        for (int dy = 0; dy < 5; dy++) begin
            for (int dx = 0; dx < 5; dx++) begin
                send_pkt(dx, dy, (dx + dy) % 3, (dx * 5 + dy) % 3,
                         ((dx + dy) % 2) == 1, dx == dy);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule